// File: doc/BRIEF.md
# Hybrid Slot/Token Bus Arbiter

This block decides which of several initiators may drive a shared bus during each time slot. Time is cut into slots of a fixed number of clocks, and a wheel of slots repeats without pause. A programmable table can give any slot to one initiator. That owner wins the slot whenever it asks for it. When the slot has no owner, or its owner does not use it, the slot is offered to a round-robin tier. In that tier a token walks a programmable order of initiators, and the first requester found from the token onward wins.

A two-bit policy for each initiator says whether it may win through its own slots, through the token, through both, or not at all. A spacing setting for each initiator makes it sit out a number of slots after each grant. The winner leaves the block as a one-hot grant with a valid strobe, after a programmable delay of 2 to 7 clocks. All settings are held in shadow copies. These copies are refreshed only in reset and on the last clock of a frame, so one frame never mixes old and new settings. The block assumes that `SLOT_CYCLES` is at least 8 and that the order table is a permutation.

Top module: `hybrid_bus_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the wheel returns to slot 0 with phase 0, the token goes to order position 0, every spacing counter clears and every pending grant is dropped. `gnt_valid` and `gnt` read zero from the first edge of reset until a grant falls due.
- R2: Each slot lasts `SLOT_CYCLES` clocks. The arbitration decision is taken at the first edge of each slot, using `req` as sampled at that edge. The slot index counts 0 up to the wheel maximum (`cfg_wheel_max`) and then restarts at 0.
- R3: The entry for slot s is `cfg_slot_map[s*(IDX_W+1) +: IDX_W+1]`. Its top bit marks the slot as owned and its low `IDX_W` bits name the owner. An owner wins its slot, whatever the token state, when it requests, when it is outside its spacing window and when its policy allows slot wins.
- R4: A slot that is not taken under R3 goes to the token tier. The scan starts at the token's order position and wraps around, where position p holds initiator `cfg_pass_order[p*IDX_W +: IDX_W]`. It grants the first initiator that requests, is outside its spacing window and is allowed token wins. The token then moves to the position just after the winner.
- R5: If neither tier finds a candidate, the slot issues no grant and the token stays where it is.
- R6: The policy of initiator i is `cfg_policy[2*i +: 2]`. Bit 0 allows wins through owned slots and bit 1 allows wins through the token. An initiator whose policy is 00 is never granted.
- R7: The grant for a slot decided at edge e is visible, as a one-clock pulse, after edge e+L-1, where L is `cfg_latency`. A setting of 0 or 1 acts as 2.
- R8: The spacing of initiator i is G = `cfg_min_gap[i*GAP_W +: GAP_W]`. After a grant to i in slot s, the requests of i are ignored in slots s+1 to s+G.
- R9: `gnt` is one-hot when `gnt_valid` is high and all zero otherwise. At most one grant is issued per slot.
- R10: A configuration change made in the middle of a frame has no effect on the rest of that frame. It takes effect from slot 0 of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | N_INIT | Request line of each initiator |
| cfg_slot_map | input | MAX_SLOTS*(IDX_W+1) | Owned flag and owner index for each slot |
| cfg_pass_order | input | N_INIT*IDX_W | Initiator held at each token position |
| cfg_policy | input | 2*N_INIT | Slot-win and token-win permission bits for each initiator |
| cfg_min_gap | input | N_INIT*GAP_W | Number of slots each initiator sits out after a grant |
| cfg_latency | input | 3 | Delay from decision to grant output, 2 to 7 |
| cfg_wheel_max | input | SLOT_W | Index of the last slot in a frame |
| gnt | output | N_INIT | One-hot grant |
| gnt_valid | output | 1 | Grant strobe |

## Verification
The decision for slot k after reset release is taken at edge 1+k*SLOT_CYCLES, and its grant is due L-1 edges later. The bench therefore keeps an edge count from release. It drives every input at a falling edge and predicts, for each edge, whether a grant is due and to whom. It compares `gnt_valid` and `gnt` at the following falling edge, and a pulse in any other cycle counts as a mismatch. Hand-written grant orders and the cycle of the first and second pulse for latencies 2, 7 and 0 check the same timing a second time without the bench's model.

// File: rtl/hyarb_pkg.sv
// Package: shared constants for the hybrid slot/token arbiter.
// Assumes: policy fields are two bits wide, slot wins on bit 0, token wins on bit 1.
package hyarb_pkg;
    localparam int POL_SLICE_BIT = 0;
    localparam int POL_TOKEN_BIT = 1;
    localparam int LAT_FLOOR     = 2;
    localparam int LAT_CEIL      = 7;

    typedef enum logic [1:0] {
        POL_NONE  = 2'b00,
        POL_SLICE = 2'b01,
        POL_TOKEN = 2'b10,
        POL_BOTH  = 2'b11
    } policy_e;
endpackage

// File: rtl/hyarb_wheel.sv
// Module: hyarb_wheel
// Counts clocks within a slot and slots within a frame. It flags the first
// clock of each slot (decision) and the last clock of each frame.
// Assumes: wheel_max is stable except on the frame_end edge.
module hyarb_wheel #(
    parameter int MAX_SLOTS   = 8,
    parameter int SLOT_CYCLES = 8,
    localparam int SLOT_W = $clog2(MAX_SLOTS),
    localparam int PH_W   = $clog2(SLOT_CYCLES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] wheel_max,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              dec_stb,
    output logic              frame_end
);
    logic [PH_W-1:0] phase;
    logic            slot_last;

    assign slot_last = (phase == PH_W'(SLOT_CYCLES - 1));
    assign dec_stb   = (phase == '0);
    assign frame_end = slot_last && (slot_idx == wheel_max);

    // Phase counter: steps each clock, restarts at each slot boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)         phase <= '0;
        else if (slot_last) phase <= '0;
        else                phase <= phase + 1'b1;
    end

    // Slot counter: steps at slot boundaries, wraps after the wheel maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)         slot_idx <= '0;
        else if (frame_end) slot_idx <= '0;
        else if (slot_last) slot_idx <= slot_idx + 1'b1;
    end
endmodule

// File: rtl/hyarb_cfg_shadow.sv
// Module: hyarb_cfg_shadow
// Holds the working copy of every setting. The copy is loaded during reset and
// on the last clock of each frame, and the latency is clamped to its floor.
// Assumes: the latency field cannot exceed the pipeline depth.
module hyarb_cfg_shadow
    import hyarb_pkg::*;
#(
    parameter int N_INIT    = 4,
    parameter int MAX_SLOTS = 8,
    parameter int GAP_W     = 3,
    localparam int IDX_W  = $clog2(N_INIT),
    localparam int SLOT_W = $clog2(MAX_SLOTS),
    localparam int ENT_W  = IDX_W + 1,
    localparam int LAT_W  = $clog2(LAT_CEIL + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_end,
    input  logic [MAX_SLOTS*ENT_W-1:0]  cfg_slot_map,
    input  logic [N_INIT*IDX_W-1:0]     cfg_pass_order,
    input  logic [2*N_INIT-1:0]         cfg_policy,
    input  logic [N_INIT*GAP_W-1:0]     cfg_min_gap,
    input  logic [LAT_W-1:0]            cfg_latency,
    input  logic [SLOT_W-1:0]           cfg_wheel_max,
    output logic [MAX_SLOTS*ENT_W-1:0]  sh_map,
    output logic [N_INIT*IDX_W-1:0]     sh_order,
    output logic [2*N_INIT-1:0]         sh_policy,
    output logic [N_INIT*GAP_W-1:0]     sh_gap,
    output logic [LAT_W-1:0]            sh_lat,
    output logic [SLOT_W-1:0]           sh_wmax
);
    logic [LAT_W-1:0] lat_clamped;

    assign lat_clamped = (cfg_latency < LAT_W'(LAT_FLOOR)) ? LAT_W'(LAT_FLOOR) : cfg_latency;

    // Shadow load: reset or frame boundary, never in the middle of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_end) begin
            sh_map    <= cfg_slot_map;
            sh_order  <= cfg_pass_order;
            sh_policy <= cfg_policy;
            sh_gap    <= cfg_min_gap;
            sh_lat    <= lat_clamped;
            sh_wmax   <= cfg_wheel_max;
        end
    end
endmodule

// File: rtl/hyarb_select.sv
// Module: hyarb_select
// Two-tier choice for the current slot. The slot owner wins first, and the
// token scan handles the rest. Also holds the token position and the spacing
// counter of each initiator.
// Assumes: the order table is a permutation of the initiators.
module hyarb_select
    import hyarb_pkg::*;
#(
    parameter int N_INIT    = 4,
    parameter int MAX_SLOTS = 8,
    parameter int GAP_W     = 3,
    localparam int IDX_W  = $clog2(N_INIT),
    localparam int SLOT_W = $clog2(MAX_SLOTS),
    localparam int ENT_W  = IDX_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        dec_stb,
    input  logic [SLOT_W-1:0]           slot_idx,
    input  logic [N_INIT-1:0]           req,
    input  logic [MAX_SLOTS*ENT_W-1:0]  sh_map,
    input  logic [N_INIT*IDX_W-1:0]     sh_order,
    input  logic [2*N_INIT-1:0]         sh_policy,
    input  logic [N_INIT*GAP_W-1:0]     sh_gap,
    output logic                        win_valid,
    output logic [IDX_W-1:0]            win_idx
);
    logic [IDX_W-1:0] tok_pos;
    logic [GAP_W-1:0] gap_cnt [N_INIT];
    logic [N_INIT-1:0] slice_ok, token_ok;
    logic [ENT_W-1:0] own_ent;
    logic [IDX_W-1:0] owner;
    logic             slot_win;
    logic             tok_hit;
    logic [IDX_W-1:0] tok_idx, tok_hit_pos, tok_next;

    // Per-initiator eligibility for each tier.
    for (genvar gi = 0; gi < N_INIT; gi++) begin : g_elig
        assign slice_ok[gi] = req[gi] && (gap_cnt[gi] == '0) && sh_policy[2*gi + POL_SLICE_BIT];
        assign token_ok[gi] = req[gi] && (gap_cnt[gi] == '0) && sh_policy[2*gi + POL_TOKEN_BIT];
    end

    assign own_ent  = sh_map[int'(slot_idx)*ENT_W +: ENT_W];
    assign owner    = own_ent[IDX_W-1:0];
    assign slot_win = own_ent[IDX_W] && slice_ok[owner];

    // Token tier: scan the order from the token position, first eligible wins.
    always_comb begin
        tok_hit     = 1'b0;
        tok_idx     = '0;
        tok_hit_pos = '0;
        for (int k = 0; k < N_INIT; k++) begin
            int pos_k;
            logic [IDX_W-1:0] cand;
            pos_k = (int'(tok_pos) + k) % N_INIT;
            cand  = sh_order[pos_k*IDX_W +: IDX_W];
            if (!tok_hit && token_ok[cand]) begin
                tok_hit     = 1'b1;
                tok_idx     = cand;
                tok_hit_pos = IDX_W'(pos_k);
            end
        end
    end

    assign tok_next  = (tok_hit_pos == IDX_W'(N_INIT - 1)) ? '0 : tok_hit_pos + 1'b1;
    assign win_valid = slot_win || tok_hit;
    assign win_idx   = slot_win ? owner : tok_idx;

    // Token position: moves only after a token-tier win.
    always_ff @(posedge clk) begin
        if (!rst_n)                          tok_pos <= '0;
        else if (dec_stb && !slot_win && tok_hit) tok_pos <= tok_next;
    end

    // Spacing counters: reload on a win, count down once per slot.
    for (genvar gi = 0; gi < N_INIT; gi++) begin : g_gap
        always_ff @(posedge clk) begin
            if (!rst_n)
                gap_cnt[gi] <= '0;
            else if (dec_stb) begin
                if (win_valid && (win_idx == IDX_W'(gi))) gap_cnt[gi] <= sh_gap[gi*GAP_W +: GAP_W];
                else if (gap_cnt[gi] != '0)               gap_cnt[gi] <= gap_cnt[gi] - 1'b1;
            end
        end
    end
endmodule

// File: rtl/hyarb_delay.sv
// Module: hyarb_delay
// Shift register that carries each decision down a fixed-depth line. The
// output tap is picked by the latency, giving a one-hot grant and a strobe.
// Assumes: lat is between 2 and DEPTH.
module hyarb_delay #(
    parameter int N_INIT = 4,
    parameter int DEPTH  = 7,
    localparam int IDX_W = $clog2(N_INIT),
    localparam int LAT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic [LAT_W-1:0]  lat,
    output logic [N_INIT-1:0] gnt,
    output logic              gnt_valid
);
    logic             stg_v [DEPTH];
    logic [IDX_W-1:0] stg_i [DEPTH];
    logic [LAT_W-1:0] tap;

    // Stage shift: the decision enters stage 0 and moves one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                stg_v[k] <= 1'b0;
                stg_i[k] <= '0;
            end
        end else begin
            stg_v[0] <= push;
            stg_i[0] <= push_idx;
            for (int k = 1; k < DEPTH; k++) begin
                stg_v[k] <= stg_v[k-1];
                stg_i[k] <= stg_i[k-1];
            end
        end
    end

    assign tap       = lat - 1'b1;
    assign gnt_valid = stg_v[tap];

    for (genvar gi = 0; gi < N_INIT; gi++) begin : g_onehot
        assign gnt[gi] = gnt_valid && (stg_i[tap] == IDX_W'(gi));
    end
endmodule

// File: rtl/hybrid_bus_arbiter.sv
// Module: hybrid_bus_arbiter
// Top level. It joins the slot wheel, the settings shadow, the two-tier
// selector and the latency line.
// Assumes: SLOT_CYCLES >= 8, so every grant leaves before the next frame's settings load.
module hybrid_bus_arbiter
    import hyarb_pkg::*;
#(
    parameter int N_INIT      = 4,
    parameter int MAX_SLOTS   = 8,
    parameter int SLOT_CYCLES = 8,
    parameter int GAP_W       = 3,
    localparam int IDX_W  = $clog2(N_INIT),
    localparam int SLOT_W = $clog2(MAX_SLOTS),
    localparam int ENT_W  = IDX_W + 1,
    localparam int LAT_W  = $clog2(LAT_CEIL + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_INIT-1:0]           req,
    input  logic [MAX_SLOTS*ENT_W-1:0]  cfg_slot_map,
    input  logic [N_INIT*IDX_W-1:0]     cfg_pass_order,
    input  logic [2*N_INIT-1:0]         cfg_policy,
    input  logic [N_INIT*GAP_W-1:0]     cfg_min_gap,
    input  logic [LAT_W-1:0]            cfg_latency,
    input  logic [SLOT_W-1:0]           cfg_wheel_max,
    output logic [N_INIT-1:0]           gnt,
    output logic                        gnt_valid
);
    logic [SLOT_W-1:0]          slot_idx;
    logic                       dec_stb, frame_end;
    logic [MAX_SLOTS*ENT_W-1:0] sh_map;
    logic [N_INIT*IDX_W-1:0]    sh_order;
    logic [2*N_INIT-1:0]        sh_policy;
    logic [N_INIT*GAP_W-1:0]    sh_gap;
    logic [LAT_W-1:0]           sh_lat;
    logic [SLOT_W-1:0]          sh_wmax;
    logic                       win_valid;
    logic [IDX_W-1:0]           win_idx;

    hyarb_wheel #(.MAX_SLOTS(MAX_SLOTS), .SLOT_CYCLES(SLOT_CYCLES)) u_wheel (
        .clk(clk), .rst_n(rst_n), .wheel_max(sh_wmax),
        .slot_idx(slot_idx), .dec_stb(dec_stb), .frame_end(frame_end)
    );

    hyarb_cfg_shadow #(.N_INIT(N_INIT), .MAX_SLOTS(MAX_SLOTS), .GAP_W(GAP_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end),
        .cfg_slot_map(cfg_slot_map), .cfg_pass_order(cfg_pass_order),
        .cfg_policy(cfg_policy), .cfg_min_gap(cfg_min_gap),
        .cfg_latency(cfg_latency), .cfg_wheel_max(cfg_wheel_max),
        .sh_map(sh_map), .sh_order(sh_order), .sh_policy(sh_policy),
        .sh_gap(sh_gap), .sh_lat(sh_lat), .sh_wmax(sh_wmax)
    );

    hyarb_select #(.N_INIT(N_INIT), .MAX_SLOTS(MAX_SLOTS), .GAP_W(GAP_W)) u_select (
        .clk(clk), .rst_n(rst_n), .dec_stb(dec_stb), .slot_idx(slot_idx),
        .req(req), .sh_map(sh_map), .sh_order(sh_order),
        .sh_policy(sh_policy), .sh_gap(sh_gap),
        .win_valid(win_valid), .win_idx(win_idx)
    );

    hyarb_delay #(.N_INIT(N_INIT), .DEPTH(LAT_CEIL)) u_delay (
        .clk(clk), .rst_n(rst_n), .push(dec_stb && win_valid),
        .push_idx(win_idx), .lat(sh_lat), .gnt(gnt), .gnt_valid(gnt_valid)
    );
endmodule

// File: rtl/hyarb_checks.sv
// Module: hyarb_checks
// Property checker for hybrid_bus_arbiter, attached by the bind below.
// Assumes: SLOT_CYCLES >= 8, so grant pulses never touch each other.
module hyarb_checks #(
    parameter int N_INIT = 4,
    parameter int IDX_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_INIT-1:0] req,
    input logic [N_INIT-1:0] gnt,
    input logic              gnt_valid,
    input logic              dec_stb,
    input logic              win_valid,
    input logic [IDX_W-1:0]  win_idx,
    input logic [2*N_INIT-1:0] sh_policy
);
    logic [1:0] granted_pol;

    // Policy field of whichever initiator the output grant names.
    always_comb begin
        granted_pol = 2'b00;
        for (int i = 0; i < N_INIT; i++)
            if (gnt[i]) granted_pol = sh_policy[2*i +: 2];
    end

    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> ($countones(gnt) == 1));

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_valid |-> (gnt == '0));

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |=> !gnt_valid);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !gnt_valid);

    p_policy_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (granted_pol != 2'b00));

    p_requester_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_stb && win_valid) |-> req[win_idx]);
endmodule

bind hybrid_bus_arbiter hyarb_checks #(.N_INIT(N_INIT), .IDX_W(IDX_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .gnt_valid(gnt_valid),
    .dec_stb(dec_stb), .win_valid(win_valid), .win_idx(win_idx),
    .sh_policy(sh_policy)
);

// File: tb/test_hybrid_bus_arbiter.sv
// Bench: directed scenarios, one task each, with a cycle-exact prediction of the grant output.
module test_hybrid_bus_arbiter;
    import hyarb_pkg::*;

    localparam int N  = 4;
    localparam int MS = 8;
    localparam int SC = 8;
    localparam int GW = 3;
    localparam int IW = 2;
    localparam int EW = 3;
    localparam int SW = 3;
    localparam int LW = 3;
    localparam time TCK = 20ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]     req = '0;
    logic [MS*EW-1:0] cfg_map = '0;
    logic [N*IW-1:0]  cfg_order = '0;
    logic [2*N-1:0]   cfg_pol = '0;
    logic [N*GW-1:0]  cfg_gap = '0;
    logic [LW-1:0]    cfg_lat = 3'd2;
    logic [SW-1:0]    cfg_wmax = 3'd3;
    logic [N-1:0]     gnt;
    logic             gnt_valid;

    // Settings applied at the change cycle of a run.
    logic [N-1:0]     alt_req;
    logic [MS*EW-1:0] alt_map;
    logic [N*IW-1:0]  alt_order;

    int n_chk = 0;
    int n_bad = 0;

    // Model state and its copy of the settings.
    int m_tok, m_slot;
    int m_gap [N];
    logic [MS*EW-1:0] s_map;
    logic [N*IW-1:0]  s_order;
    logic [2*N-1:0]   s_pol;
    logic [N*GW-1:0]  s_gap;
    int s_lat, s_wmax;

    logic       ev [0:1023];
    logic [N-1:0] eg [0:1023];
    int obs_idx [0:127];
    int obs_cyc [0:127];
    int n_obs;

    always #(TCK/2) clk = ~clk;

    hybrid_bus_arbiter #(.N_INIT(N), .MAX_SLOTS(MS), .SLOT_CYCLES(SC), .GAP_W(GW)) i_hybrid_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req),
        .cfg_slot_map(cfg_map), .cfg_pass_order(cfg_order), .cfg_policy(cfg_pol),
        .cfg_min_gap(cfg_gap), .cfg_latency(cfg_lat), .cfg_wheel_max(cfg_wmax),
        .gnt(gnt), .gnt_valid(gnt_valid)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic cfg_default();
        cfg_map = '0;
        cfg_order = {2'd3, 2'd2, 2'd1, 2'd0};
        cfg_pol = {4{POL_BOTH}};
        cfg_gap = '0;
        cfg_lat = 3'd2;
        cfg_wmax = 3'd3;
        req = '0;
        alt_req = '0;
        alt_map = '0;
        alt_order = cfg_order;
    endtask

    task automatic set_slot(input int s, input int owner);
        cfg_map[s*EW +: EW] = {1'b1, IW'(owner)};
    endtask

    // Reference decision for one slot, from the requirement text.
    task automatic m_decide(input int c);
        logic [EW-1:0] ent;
        int owner, win;
        if (m_slot == 0) begin
            s_map = cfg_map; s_order = cfg_order; s_pol = cfg_pol; s_gap = cfg_gap;
            s_lat = (cfg_lat < 2) ? 2 : int'(cfg_lat);
            s_wmax = int'(cfg_wmax);
        end
        ent = s_map[m_slot*EW +: EW];
        owner = int'(ent[IW-1:0]);
        win = -1;
        if (ent[IW] && req[owner] && m_gap[owner] == 0 && s_pol[2*owner]) win = owner;
        else begin
            for (int k = 0; k < N; k++) begin
                int p, cand;
                p = (m_tok + k) % N;
                cand = int'(s_order[p*IW +: IW]);
                if (win < 0 && req[cand] && m_gap[cand] == 0 && s_pol[2*cand+1]) begin
                    win = cand;
                    m_tok = (p + 1) % N;
                end
            end
        end
        for (int i = 0; i < N; i++) begin
            if (i == win) m_gap[i] = int'(s_gap[i*GW +: GW]);
            else if (m_gap[i] > 0) m_gap[i] = m_gap[i] - 1;
        end
        if (win >= 0) begin
            ev[c + s_lat - 1] = 1'b1;
            eg[c + s_lat - 1] = N'(1) << win;
        end
        m_slot = (m_slot == s_wmax) ? 0 : m_slot + 1;
    endtask

    // Reset, then run nslots slots, comparing the output every cycle.
    task automatic run(input string tag, input int nslots, input int chg_at);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R1", "output during reset", int'({gnt_valid, gnt}), 0);
        end
        rst_n = 1'b1;
        m_tok = 0; m_slot = 0; n_obs = 0;
        for (int i = 0; i < N; i++) m_gap[i] = 0;
        for (int i = 0; i < 1024; i++) begin ev[i] = 1'b0; eg[i] = '0; end
        for (int c = 1; c <= nslots*SC; c++) begin
            if ((c - 1) % SC == 0) m_decide(c);
            if (c == chg_at) begin
                req = alt_req; cfg_map = alt_map; cfg_order = alt_order;
            end
            @(posedge clk);
            @(negedge clk);
            // R9: one pulse per slot, one-hot, exactly in the due cycle
            chk({tag, " R9"}, $sformatf("cycle %0d {valid,gnt}", c), int'({gnt_valid, gnt}), int'({ev[c], eg[c]}));
            if (gnt_valid && n_obs < 128) begin
                for (int i = 0; i < N; i++) if (gnt[i]) obs_idx[n_obs] = i;
                obs_cyc[n_obs] = c;
                n_obs++;
            end
        end
    endtask

    task automatic chk_seq(input string tag, input int n, input int seq [8]);
        chk(tag, "grant count", (n_obs >= n) ? n : n_obs, n);
        for (int k = 0; k < n && k < n_obs; k++)
            chk(tag, $sformatf("grant %0d winner", k), obs_idx[k], seq[k]);
    endtask

    // R1 / R4: token starts at order position 0 and walks the order.
    task automatic t_reset_token();
        cfg_default();
        cfg_order = {2'd1, 2'd3, 2'd0, 2'd2};
        req = 4'b1111;
        run("R4", 6, -1);
        chk_seq("R1", 6, '{2, 0, 3, 1, 2, 0, 0, 0});
    endtask

    // R2 / R3: owners win their slots, token fills the unowned one, wheel wraps.
    task automatic t_slot_owner();
        cfg_default();
        set_slot(0, 3); set_slot(1, 1); set_slot(3, 3);
        req = 4'b1111;
        run("R3", 8, -1);
        chk_seq("R2", 8, '{3, 1, 0, 3, 3, 1, 1, 3});
    endtask

    // R3 / R4: owner not requesting, so its slots go to the token tier.
    task automatic t_refusal();
        cfg_default();
        cfg_wmax = 3'd1;
        set_slot(0, 0); set_slot(1, 0);
        req = 4'b1010;
        run("R4", 4, -1);
        chk_seq("R3", 4, '{1, 3, 1, 3, 0, 0, 0, 0});
    endtask

    // R5: idle slots issue nothing and leave the token in place.
    task automatic t_idle();
        cfg_default();
        cfg_order = {2'd0, 2'd1, 2'd2, 2'd3};
        alt_order = cfg_order;
        alt_req = 4'b1111;
        run("R5", 8, 3*SC + 4);
        chk_seq("R5", 4, '{3, 2, 1, 0, 0, 0, 0, 0});
        chk("R5", "total grants", n_obs, 4);
    endtask

    // R6: slot-only, none and token-only policies.
    task automatic t_policy();
        cfg_default();
        cfg_wmax = 3'd1;
        set_slot(0, 0); set_slot(1, 2);
        cfg_pol = {POL_TOKEN, POL_NONE, POL_SLICE, POL_SLICE};
        req = 4'b1111;
        run("R6", 4, -1);
        chk_seq("R6", 4, '{0, 3, 0, 3, 0, 0, 0, 0});
    endtask

    // R7: first pulse after edge L, second one slot later; 0 acts as 2.
    task automatic t_latency(input int lat, input int eff);
        cfg_default();
        cfg_lat = LW'(lat);
        req = 4'b0001;
        run("R7", 3, -1);
        chk("R7", $sformatf("lat %0d first pulse cycle", lat), (n_obs > 0) ? obs_cyc[0] : -1, eff);
        chk("R7", $sformatf("lat %0d second pulse cycle", lat), (n_obs > 1) ? obs_cyc[1] : -1, SC + eff);
    endtask

    // R8: initiator 0 sits out two slots after each grant.
    task automatic t_spacing();
        cfg_default();
        cfg_wmax = 3'd7;
        cfg_gap[0*GW +: GW] = 3'd2;
        req = 4'b0011;
        run("R8", 7, -1);
        chk_seq("R8", 7, '{0, 1, 1, 0, 1, 1, 0, 0});
    endtask

    // R10: a change in mid-frame waits for the next frame.
    task automatic t_midframe();
        cfg_default();
        req = 4'b1111;
        alt_req = 4'b1111;
        for (int s = 0; s < MS; s++) alt_map[s*EW +: EW] = {1'b1, 2'd1};
        alt_order = {2'd0, 2'd1, 2'd2, 2'd3};
        run("R10", 8, SC + 4);
        chk_seq("R10", 8, '{0, 1, 2, 3, 1, 1, 1, 1});
    endtask

    initial begin
        #(TCK * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        cfg_default();
        t_reset_token();
        t_slot_owner();
        t_refusal();
        t_idle();
        t_policy();
        t_latency(2, 2);
        t_latency(7, 7);
        t_latency(0, 2);
        t_spacing();
        t_midframe();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule